// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block merges level-sensitive interrupt requests from a set of device slots onto four shared interrupt lines. Every slot owns four request pins; each pin is steered onto one of the four lines by a rotation that depends on the slot's number. The target line is the pin index plus the slot number, modulo four. Any number of pins may therefore share one line.

Each line does not come from a plain OR gate. It keeps an up/down count of the pins that are currently asserted and counted against it. A pin counts only on a real level change: a rise adds one to the line the pin maps to, and a fall removes one. The pin remembers the line it was counted on, so a fall always undoes its own rise, even if the slot number was changed in between. A line is high while its count is nonzero. Several rises and falls in one cycle are summed per line.

Top module: `irq_line_aggregator`

## Requirements
- R1: Synchronous active-high reset clears every stored pin level, every latched line and every counter, so all four lines are low after reset.
- R2: Request bit `s*4+p` of `req_i` is pin p of slot s. The two-bit slot number of slot s is `slot_num_i[2*s+1:2*s]`. A rising pin is counted on line `(p + slot number) mod 4`, which is bit index of `irq_o`.
- R3: A line is high exactly when at least one counted pin is asserted on it, so a line shared by two high pins stays high when only one of them drops.
- R4: A pin held at the level already stored for it causes no count change, however many cycles it is held; a single fall then takes its line low.
- R5: A rising pin adds one to its line's count and a falling pin subtracts one.
- R6: All rises and falls in one cycle are summed per line, so a fall and a rise on the same line in the same cycle leave that line high.
- R7: A falling pin decrements the line it was counted on at its rise, even if its slot number changed while it was high.
- R8: The lines change on the clock edge that samples the new request levels; a change on `req_i` is not visible on `irq_o` before that edge.
- R9: No line counter ever exceeds the number of request pins, so it never wraps below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_SLOTS*4 | Level requests, four per slot |
| slot_num_i | input | NUM_SLOTS*2 | Two-bit slot number per slot, used for the rotation |
| irq_o | output | 4 | Shared interrupt lines |

## Verification
The case that matters most is a fall and a rise landing on the same line in the same cycle. The line must stay high because the two deltas cancel, and it must not glitch or miscount. The bench provokes this on purpose by dropping one pin and raising another pin that maps to the same line on the same edge. Random traffic also produces many such coincidences, and slot renumbering is mixed in while pins are high. Each cycle is judged against a bench model that keeps its own per-pin levels, latched lines and per-line counts.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int LINES  = 4;
    localparam int PINS   = 4;
    localparam int LINE_W = $clog2(LINES);

    typedef logic [LINE_W-1:0] line_t;

    // Stored view of one request pin: its last level and the line it was counted on.
    typedef struct packed {
        logic  level;
        line_t line;
    } pin_state_t;

    // Rotate a pin onto a shared line by the slot number.
    function automatic line_t swizzle(input line_t pin, input line_t slot_num);
        line_t sum;
        sum = pin + slot_num;
        return sum;
    endfunction

endpackage

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker
    import irq_agg_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [PINS-1:0]              req_i,
    input  line_t                        slot_num_i,
    output logic [PINS-1:0][LINES-1:0]   rise_o,
    output logic [PINS-1:0][LINES-1:0]   fall_o
);

    pin_state_t [PINS-1:0] st_q;

    always_comb begin
        for (int p = 0; p < PINS; p++) begin
            rise_o[p] = '0;
            fall_o[p] = '0;
            if (req_i[p] && !st_q[p].level)
                rise_o[p][swizzle(line_t'(p), slot_num_i)] = 1'b1;
            if (!req_i[p] && st_q[p].level)
                fall_o[p][st_q[p].line] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            for (int p = 0; p < PINS; p++) begin
                if (req_i[p] != st_q[p].level) begin
                    st_q[p].level <= req_i[p];
                    if (req_i[p])
                        st_q[p].line <= swizzle(line_t'(p), slot_num_i);
                end
            end
        end
    end

endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter #(
    parameter int SRC   = 16,
    parameter int CNT_W = $clog2(SRC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC-1:0]   inc_i,
    input  logic [SRC-1:0]   dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             active_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] n_inc;
    logic [CNT_W-1:0] n_dec;

    always_comb begin
        n_inc = '0;
        n_dec = '0;
        for (int i = 0; i < SRC; i++) begin
            n_inc = n_inc + CNT_W'(inc_i[i]);
            n_dec = n_dec + CNT_W'(dec_i[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + n_inc - n_dec;
    end

    assign cnt_o    = cnt_q;
    assign active_o = (cnt_q != '0);

endmodule

// File: rtl/irq_line_aggregator.sv
module irq_line_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_SLOTS*PINS-1:0]     req_i,
    input  logic [NUM_SLOTS*LINE_W-1:0]   slot_num_i,
    output logic [LINES-1:0]              irq_o
);

    localparam int SRC   = NUM_SLOTS * PINS;
    localparam int CNT_W = $clog2(SRC + 1);

    logic [NUM_SLOTS-1:0][PINS-1:0][LINES-1:0] rise;
    logic [NUM_SLOTS-1:0][PINS-1:0][LINES-1:0] fall;
    logic [LINES-1:0][SRC-1:0]                 inc_by_line;
    logic [LINES-1:0][SRC-1:0]                 dec_by_line;
    logic [LINES-1:0][CNT_W-1:0]               line_cnt;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        irq_pin_tracker u_trk (
            .clk        (clk),
            .rst        (rst),
            .req_i      (req_i[s*PINS +: PINS]),
            .slot_num_i (slot_num_i[s*LINE_W +: LINE_W]),
            .rise_o     (rise[s]),
            .fall_o     (fall[s])
        );
        for (genvar p = 0; p < PINS; p++) begin : g_pin
            for (genvar k = 0; k < LINES; k++) begin : g_route
                assign inc_by_line[k][s*PINS+p] = rise[s][p][k];
                assign dec_by_line[k][s*PINS+p] = fall[s][p][k];
            end
        end
    end

    for (genvar k = 0; k < LINES; k++) begin : g_line
        irq_line_counter #(.SRC(SRC), .CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .inc_i    (inc_by_line[k]),
            .dec_i    (dec_by_line[k]),
            .cnt_o    (line_cnt[k]),
            .active_o (irq_o[k])
        );
    end

endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
    import irq_agg_pkg::*;
#(
    parameter int SRC   = 16,
    parameter int CNT_W = $clog2(SRC + 1)
) (
    input logic                       clk,
    input logic                       rst,
    input logic [SRC-1:0]             req_i,
    input logic [LINES-1:0]           irq_o,
    input logic [LINES-1:0][CNT_W-1:0] line_cnt
);

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    for (genvar k = 0; k < LINES; k++) begin : g_chk
        // R9
        cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
            armed |-> line_cnt[k] <= CNT_W'(SRC));
    end

    // R3
    quiet_low_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i == '0) |=> (irq_o == '0));

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $stable(req_i)) |=> $stable(irq_o));

    // R8
    rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && ((irq_o & ~$past(irq_o)) != '0)) |-> ($past(req_i) != '0));

endmodule

bind irq_line_aggregator irq_agg_checker #(.SRC(SRC), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_i    (req_i),
    .irq_o    (irq_o),
    .line_cnt (line_cnt)
);

// File: tb/irq_line_aggregator_test.sv
module irq_line_aggregator_test;

    localparam int CLK_PERIOD = 10;
    localparam int NSLOT      = 4;
    localparam int NSRC       = NSLOT * 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NSRC-1:0]      req = '0;
    logic [NSLOT*2-1:0]   slots = '0;
    logic [3:0]           irq;

    int vectors  = 0;
    int miscomp  = 0;
    bit finished = 1'b0;

    int m_level [NSRC];
    int m_line  [NSRC];
    int m_cnt   [4];

    irq_line_aggregator #(.NUM_SLOTS(NSLOT)) uut (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req),
        .slot_num_i (slots),
        .irq_o      (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [3:0] model_irq();
        logic [3:0] r;
        for (int k = 0; k < 4; k++) r[k] = (m_cnt[k] != 0);
        return r;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NSRC; i++) begin m_level[i] = 0; m_line[i] = 0; end
        for (int k = 0; k < 4; k++) m_cnt[k] = 0;
    endtask

    task automatic model_step(input logic [NSRC-1:0] r, input logic [NSLOT*2-1:0] sl);
        for (int s = 0; s < NSLOT; s++) begin
            for (int p = 0; p < 4; p++) begin
                int i;
                int lv;
                i  = s*4 + p;
                lv = int'(r[i]);
                if (lv != m_level[i]) begin
                    if (lv == 1) begin
                        m_line[i] = (p + int'(sl[s*2 +: 2])) % 4;
                        m_cnt[m_line[i]]++;
                    end else begin
                        m_cnt[m_line[i]]--;
                    end
                    m_level[i] = lv;
                end
            end
        end
    endtask

    task automatic check(input string tag, input logic [3:0] exp);
        vectors++;
        if (irq !== exp) begin
            miscomp++;
            $display("FAIL %s irq_o actual=%b expected=%b", tag, irq, exp);
        end
    endtask

    // Called at a falling edge: drive, let one rising edge pass, check at next falling edge.
    task automatic apply(input logic [NSRC-1:0] r, input logic [NSLOT*2-1:0] sl, input string tag);
        req   = r;
        slots = sl;
        model_step(r, sl);
        @(negedge clk);
        check(tag, model_irq());
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            miscomp++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
            $finish;
        end
    end

    initial begin
        logic [NSRC-1:0]    r;
        logic [NSLOT*2-1:0] sl;
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 after reset", 4'b0000);

        // R2: slot1 number 2, pin 3 -> line 1
        sl = 8'b00_00_10_00;
        apply(16'h0080, sl, "R2 rotation slot1 pin3");
        check("R2 explicit line1", 4'b0010);

        // R8: new request not visible before the sampling edge
        req = 16'h0081;
        #1;
        check("R8 before edge", 4'b0010);
        model_step(16'h0081, sl);
        @(negedge clk);
        check("R8 after edge", 4'b0011);

        // R4: hold the same level, then one fall each clears
        for (int n = 0; n < 5; n++) apply(16'h0081, sl, "R4 hold");
        apply(16'h0001, sl, "R4 drop one");
        check("R4 line1 low", 4'b0001);
        apply(16'h0000, sl, "R5 drop all");
        check("R5 all low", 4'b0000);

        // R3/R5: two pins on line 1, drop one, line stays
        sl = 8'b00_00_00_00;
        apply(16'h0022, sl, "R5 two rises line1");
        apply(16'h0020, sl, "R3 shared line stays");
        check("R3 line1 high", 4'b0010);

        // R6: fall and rise on line 1 in the same cycle
        apply(16'h0002, sl, "R6 swap same line");
        check("R6 line1 held", 4'b0010);
        apply(16'h0000, sl, "R6 release");

        // R7: renumber slot while pin held; fall undoes the latched line
        apply(16'h0001, sl, "R7 rise line0");
        sl = 8'b00_00_00_01;
        apply(16'h0001, sl, "R7 renumber held");
        check("R7 still line0", 4'b0001);
        apply(16'h0000, sl, "R7 fall latched line");
        check("R7 all low", 4'b0000);

        // Random traffic with occasional renumbering (R2..R7, R9)
        r  = '0;
        sl = '0;
        for (int n = 0; n < 4000; n++) begin
            for (int b = 0; b < NSRC; b++)
                if ($urandom_range(0, 3) == 0) r[b] = ~r[b];
            if ($urandom_range(0, 7) == 0) sl = NSLOT*2'($urandom);
            apply(r, sl, "R6 random");
        end

        // R1: reset mid-traffic clears all
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        req = '0;
        model_reset();
        @(negedge clk);
        check("R1 reset mid traffic", 4'b0000);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

endmodule